// File: doc/BRIEF.md
# Caliper format and rate detector

This block listens to the serial clock line of a digital measuring scale and works out what kind of instrument is attached. A request starts one classification. The block first waits for a quiet stretch on the line, which marks the space between two data bursts. It then times how long the line stays quiet before the next burst begins, and counts the falling edges in that burst until the line goes quiet again.

Two results come out of one pass. A long burst of more than 30 pulses identifies the 48-bit binary frame; a shorter burst identifies the seven-nibble frame. A burst that starts soon after the quiet stretch identifies an instrument updating at the fast rate of roughly 20 ms per reading; a later start identifies the slow rate of roughly 300 ms. If the line shows no usable activity within a timeout, the block reports that no instrument is present. All time limits are parameters in system clock cycles. The line is idle low and pulses high at the block's input; any inversion belongs outside the block.

The state machine has five states. IDLE waits for a request. SYNC waits for the quiet gap. ARMED waits for the first rising edge of a burst while the rate window runs. COUNT counts falling edges until the quiet gap returns. REPORT holds for one cycle while done is high. The transitions are: IDLE to SYNC on request; SYNC to ARMED when the gap is seen; SYNC to REPORT on timeout; ARMED to COUNT on a high line; ARMED to REPORT on timeout; COUNT to REPORT when the gap is seen; REPORT to IDLE always.

Top module: `scale_probe`

## Requirements
- R1: A request (`req_i` high at a clock edge) is taken only in IDLE; a request while a classification is running or reporting has no effect, and each accepted request yields exactly one done pulse.
- R2: After a request the block waits until the synchronized line has been low on GAP_CYC consecutive clock edges; pulses seen before that gap are not counted. A gap already in progress when the request arrives counts.
- R3: When the burst ends, `fmt_bin_o` is 1 if the burst held more than PULSE_THR falling edges and 0 otherwise (with the default threshold of 30: 30 edges give 0, 31 edges give 1).
- R4: `fast_o` is 1 when the first high level after the gap is seen less than FAST_WIN_CYC cycles after the gap was detected, and 0 otherwise.
- R5: The burst ends only when the synchronized line has been low on GAP_CYC consecutive edges; shorter low stretches inside a burst keep the count going.
- R6: If SYNC or ARMED lasts NODEV_CYC cycles or more, the block reports with `nodev_o` = 1, `fmt_bin_o` = 0 and `fast_o` = 0; any completed burst reports `nodev_o` = 0.
- R7: The edge counter saturates instead of wrapping, so a burst of 70 edges still gives `fmt_bin_o` = 1.
- R8: `done_o` is high for exactly one cycle per result, together with the new result flags; the flags then hold until the next done. After reset all outputs are 0.
- R9: `scl_i` is asynchronous and passes through SYNC_STAGES (default 2) flip-flops before any use; the state machine sees each level that many cycles late.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start one classification (taken in IDLE only) |
| scl_i | input | 1 | Scale clock line, idle low, asynchronous |
| done_o | output | 1 | One-cycle strobe when a result is ready |
| fmt_bin_o | output | 1 | 1 = long binary frame, 0 = nibble frame |
| fast_o | output | 1 | 1 = fast update rate |
| nodev_o | output | 1 | 1 = no instrument activity within the timeout |

## Verification
The bench aims at the pulse-count threshold from both sides (30 and 31 edges), since an off-by-one compare flips the format flag there, and at a 70-edge burst, where a counter that wraps would report the nibble format. It starts a request in the middle of a running burst, which a design that skipped the gap would count into a binary result, and stretches low spaces inside a burst to just under the gap, which a design with a short gap limit would cut off early. It also holds the line low forever and high forever to reach both timeouts, and repeats a request while busy, where a design that restarted would emit a second done or a changed result.

// File: rtl/scale_probe_pkg.sv
package scale_probe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_ARMED,
        ST_COUNT,
        ST_REPORT
    } probe_state_t;

endpackage

// File: rtl/sp_line_sync.sv
module sp_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic line_o,
    output logic fall_o
);
    logic [STAGES-1:0] sh_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= raw_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= {sh_q[STAGES-2:0], raw_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sh_q[STAGES-1];
    end

    assign line_o = sh_q[STAGES-1];
    assign fall_o = last_q & ~sh_q[STAGES-1];

    // R9: a high level at the output was present at the input STAGES edges earlier
    assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_o |-> $past(raw_i, STAGES));

endmodule

// File: rtl/sp_sat_count.sv
module sp_sat_count #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (clr_i)                 cnt_q <= '0;
        else if (inc_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R7: a full counter stays full instead of wrapping
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && cnt_q == TOP) |=> (cnt_q == TOP));

endmodule

// File: rtl/scale_probe.sv
module scale_probe
    import scale_probe_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned GAP_CYC      = 50_000,
    parameter int unsigned FAST_WIN_CYC = 1_250_000,
    parameter int unsigned NODEV_CYC    = 25_000_000,
    parameter int unsigned PULSE_THR    = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic scl_i,
    output logic done_o,
    output logic fmt_bin_o,
    output logic fast_o,
    output logic nodev_o
);
    localparam int unsigned T_A  = (GAP_CYC > FAST_WIN_CYC) ? GAP_CYC : FAST_WIN_CYC;
    localparam int unsigned T_MX = (T_A > NODEV_CYC) ? T_A : NODEV_CYC;
    localparam int unsigned CW   = $clog2(T_MX + 1) + 1;
    localparam int unsigned PW   = $clog2(PULSE_THR + 2) + 1;

    localparam logic [CW-1:0] GAP_L  = CW'(GAP_CYC);
    localparam logic [CW-1:0] FAST_L = CW'(FAST_WIN_CYC);
    localparam logic [CW-1:0] NDEV_L = CW'(NODEV_CYC);
    localparam logic [PW-1:0] THR_L  = PW'(PULSE_THR);

    logic          line, fall;
    probe_state_t  st_q, st_nx;
    logic [CW-1:0] low_q, age_q;
    logic [PW-1:0] pcnt_q;
    logic          age_clr, pcnt_clr, pcnt_inc;
    logic          seen_fast_q;
    logic          fmt_q, fast_q, nodev_q;

    sp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (scl_i),
        .line_o (line),
        .fall_o (fall)
    );

    // consecutive low samples of the synchronized line
    sp_sat_count #(.W(CW)) u_low (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (line),
        .inc_i (1'b1),
        .cnt_o (low_q)
    );

    // cycles spent in the current state
    assign age_clr = (st_q == ST_IDLE) || (st_nx != st_q);

    sp_sat_count #(.W(CW)) u_age (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (age_clr),
        .inc_i (1'b1),
        .cnt_o (age_q)
    );

    // falling edges inside the burst
    assign pcnt_clr = (st_q != ST_COUNT);
    assign pcnt_inc = fall;

    sp_sat_count #(.W(PW)) u_pulses (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (pcnt_clr),
        .inc_i (pcnt_inc),
        .cnt_o (pcnt_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_i) st_nx = ST_SYNC;
            end
            ST_SYNC: begin
                if (low_q >= GAP_L)       st_nx = ST_ARMED;
                else if (age_q >= NDEV_L) st_nx = ST_REPORT;
            end
            ST_ARMED: begin
                if (line)                 st_nx = ST_COUNT;
                else if (age_q >= NDEV_L) st_nx = ST_REPORT;
            end
            ST_COUNT: begin
                if (low_q >= GAP_L) st_nx = ST_REPORT;
            end
            ST_REPORT: st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // outputs: rate capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_fast_q <= 1'b0;
            fmt_q       <= 1'b0;
            fast_q      <= 1'b0;
            nodev_q     <= 1'b0;
        end else begin
            if (st_q == ST_ARMED && line)
                seen_fast_q <= (age_q < FAST_L);
            if (st_nx == ST_REPORT && st_q != ST_REPORT) begin
                if (st_q == ST_COUNT) begin
                    fmt_q   <= (pcnt_q > THR_L);
                    fast_q  <= seen_fast_q;
                    nodev_q <= 1'b0;
                end else begin
                    fmt_q   <= 1'b0;
                    fast_q  <= 1'b0;
                    nodev_q <= 1'b1;
                end
            end
        end
    end

    assign done_o    = (st_q == ST_REPORT);
    assign fmt_bin_o = fmt_q;
    assign fast_o    = fast_q;
    assign nodev_o   = nodev_q;

    // R8: done lasts one cycle
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: results only change together with a new done
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (done_o || ($stable(fmt_bin_o) && $stable(fast_o) && $stable(nodev_o))));

    // R1: a running classification never drops back to IDLE without reporting
    assert_busy_no_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SYNC || st_q == ST_ARMED || st_q == ST_COUNT) |=> (st_q != ST_IDLE));

    // R2: ARMED is entered only after a full quiet gap
    assert_gap_before_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == ST_ARMED) |-> ($past(low_q) >= GAP_L));

    // R6: a no-device report never claims a format or a rate
    assert_nodev_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && nodev_o) |-> (!fmt_bin_o && !fast_o));

endmodule

// File: tb/scale_probe_tb.sv
module scale_probe_tb;
    localparam int CLK_PERIOD = 10;
    localparam int GAP   = 20;
    localparam int FAST  = 200;
    localparam int NODEV = 1000;
    localparam int THR   = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic scl = 1'b0;
    logic done, fmt, fast, nodev;

    always #(CLK_PERIOD/2) clk = ~clk;

    scale_probe #(
        .SYNC_STAGES  (2),
        .GAP_CYC      (GAP),
        .FAST_WIN_CYC (FAST),
        .NODEV_CYC    (NODEV),
        .PULSE_THR    (THR)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .scl_i     (scl),
        .done_o    (done),
        .fmt_bin_o (fmt),
        .fast_o    (fast),
        .nodev_o   (nodev)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int dones  = 0;
    bit ended  = 0;

    // behavioural reference
    int m_st, nst, m_low, m_age, m_cnt;
    bit m_s1, m_s2, m_lnd, m_fall, m_seen, m_fmt, m_fast, m_nodev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_low = 0; m_age = 0; m_cnt = 0;
            m_s1 = 0; m_s2 = 0; m_lnd = 0; m_seen = 0;
            m_fmt = 0; m_fast = 0; m_nodev = 0;
        end else begin
            m_fall = m_lnd && !m_s2;
            nst = m_st;
            case (m_st)
                0: if (req) nst = 1;
                1: begin
                    if (m_low >= GAP) nst = 2;
                    else if (m_age >= NODEV) begin
                        nst = 4; m_nodev = 1; m_fmt = 0; m_fast = 0;
                    end
                end
                2: begin
                    if (m_s2) begin nst = 3; m_seen = (m_age < FAST); end
                    else if (m_age >= NODEV) begin
                        nst = 4; m_nodev = 1; m_fmt = 0; m_fast = 0;
                    end
                end
                3: if (m_low >= GAP) begin
                    nst = 4; m_fmt = (m_cnt > THR); m_fast = m_seen; m_nodev = 0;
                end
                default: nst = 0;
            endcase
            if (m_st == 3) begin
                if (m_fall && m_cnt < 100000) m_cnt = m_cnt + 1;
            end else m_cnt = 0;
            m_age = (m_st == 0 || nst != m_st) ? 0 : m_age + 1;
            m_low = m_s2 ? 0 : ((m_low < 100000) ? m_low + 1 : m_low);
            m_lnd = m_s2; m_s2 = m_s1; m_s1 = scl; m_st = nst;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (done) dones++;
            check(done  === (m_st == 4), "R8 R9 done timing", int'(done), int'(m_st == 4));
            check(fmt   === m_fmt,   "R3 format flag per cycle", int'(fmt), int'(m_fmt));
            check(fast  === m_fast,  "R4 rate flag per cycle", int'(fast), int'(m_fast));
            check(nodev === m_nodev, "R6 no-device flag per cycle", int'(nodev), int'(m_nodev));
            if (cyc > 150000) begin
                fails++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
                finish_run();
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();
        @(negedge clk) req = 1'b1;
        @(negedge clk) req = 1'b0;
    endtask

    task automatic burst(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            scl = 1'b1; idle(hi);
            scl = 1'b0; idle(lo);
        end
    endtask

    task automatic wait_done(input int lim, input string tag);
        int k = 0;
        while (done !== 1'b1 && k < lim) begin
            @(negedge clk); k++;
        end
        check(done === 1'b1, tag, int'(done), 1);
    endtask

    task automatic expect_result(input string tag, input bit e_fmt, input bit e_fast, input bit e_nodev);
        check(fmt === e_fmt,     {tag, " format"}, int'(fmt), int'(e_fmt));
        check(fast === e_fast,   {tag, " rate"}, int'(fast), int'(e_fast));
        check(nodev === e_nodev, {tag, " no-device"}, int'(nodev), int'(e_nodev));
        @(negedge clk);
        check(done === 1'b0, "R8 done lasts one cycle", int'(done), 0);
    endtask

    task automatic run_case(input int delay, input int n, input int lo, input string tag,
                            input bit e_fmt, input bit e_fast);
        scl = 1'b0;
        idle(30);
        pulse_req();
        idle(delay);
        burst(n, 3, lo);
        wait_done(3000, {tag, " done seen"});
        expect_result(tag, e_fmt, e_fast, 1'b0);
    endtask

    initial begin
        idle(3);
        @(negedge clk);
        check(done === 0 && fmt === 0 && fast === 0 && nodev === 0,
              "R8 reset state", int'({done, fmt, fast, nodev}), 0);
        rst_n = 1'b1;

        run_case(40,  48, 3, "R3 R4 fast binary", 1'b1, 1'b1);
        idle(30);
        check(fmt === 1'b1 && fast === 1'b1, "R8 flags held after done", int'({fmt, fast}), 3);

        run_case(500, 28, 3, "R3 R4 slow nibble", 1'b0, 1'b0);
        run_case(10,  30, 3, "R3 thirty edges", 1'b0, 1'b1);
        run_case(10,  31, 3, "R3 thirty-one edges", 1'b1, 1'b1);
        run_case(10,  70, 3, "R7 saturating count", 1'b1, 1'b1);
        run_case(10,  31, GAP - 3, "R5 long low inside burst", 1'b1, 1'b1);

        // R6: line held low, no burst after the gap
        scl = 1'b0; idle(30);
        pulse_req();
        wait_done(2000, "R6 quiet line done seen");
        expect_result("R6 quiet line", 1'b0, 1'b0, 1'b1);

        // R6: line stuck high, the gap never comes
        scl = 1'b1; idle(10);
        pulse_req();
        wait_done(2000, "R6 stuck line done seen");
        expect_result("R6 stuck line", 1'b0, 1'b0, 1'b1);
        scl = 1'b0; idle(40);

        // R2: request in the middle of a burst; only the next burst counts
        fork
            burst(40, 3, 3);
            begin idle(60); pulse_req(); end
        join
        idle(30);
        burst(28, 3, 3);
        wait_done(3000, "R2 mid-burst request done seen");
        expect_result("R2 mid-burst request", 1'b0, 1'b1, 1'b0);

        // R1: repeated requests while busy
        scl = 1'b0; idle(30);
        dones = 0;
        pulse_req();
        idle(20);
        pulse_req();
        idle(20);
        burst(31, 3, 3);
        pulse_req();
        wait_done(3000, "R1 busy request done seen");
        expect_result("R1 busy request", 1'b1, 1'b1, 1'b0);
        idle(60);
        check(dones == 1, "R1 one done per accepted request", dones, 1);

        finish_run();
    end
endmodule